// File: doc/BRIEF.md
# Indirect Register Access Bridge

A host sees a small direct register window of seven locations. Behind this window sits a larger space of internal registers that the host cannot address directly. The host first loads one or two 16-bit staging registers. It then writes an indirect address, and that write starts one internal transfer. A busy flag stays up for a fixed number of cycles while the transfer runs. When the flag drops, a write has been committed to the backing store, or the addressed word of a read has been placed in staging register 0.

The internal space is split into functional block types, each holding several units. Every unit has a 16-bit control register and a 32-bit control register. Each register has two addresses: a write address, and a read address that is the write address with bit 7 set. Both words of a 32-bit register are written in one transfer. It is read back one word per transfer, and address bit 0 selects which word. A read-only revision location identifies the hardware.

The window is a plain single-cycle register port with no flow control. The host either polls the busy flag or waits the fixed transfer time. The port never stalls, and writes made while busy are dropped.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, busy is 0 and the address register (window 0), the staging registers (windows 1 to 4), the status register (window 6) and every internal register all read 0.
- R2: A window-0 write accepted while idle starts a transfer. The status bit 0 and the `busy` output read 1 from the following cycle, for exactly BUSY_CYCLES (default 4) cycles, and then return to 0.
- R3: Host writes to any window while busy are dropped. The staging and address registers keep their values, and the running transfer is not restarted.
- R4: Indirect address layout: bits 15:12 give the block type, bits 11:8 the unit (1..NUNIT), bit 7 the direction (1 = read), and bits 3:2 the slot (1 = 16-bit register, 2 = 32-bit register). Bit 0 is the word index. Bits 6:4 and bit 1 must be 0.
- R5: A write to slot 1 stores staging register 0. Reading the same register (its write address plus 0x80) returns that value in staging register 0.
- R6: A write to slot 2 commits staging register 0 as word 0 and staging register 1 as word 1 in the same transfer. A read with bit 0 = 0 returns word 0, and a read with bit 0 = 1 returns word 1. For example, writing 0x0123 and 0x0321 reads back as 0x0123 and 0x0321.
- R7: Block types 1, 2, 3 and 9 are implemented, each as separate storage. All other type codes are unimplemented.
- R8: A transfer to an unimplemented address completes with the normal busy timing. A read returns 0 in staging register 0, and a write changes no register. Unimplemented addresses include an unknown type, unit 0 or a unit above NUNIT, a bad slot, nonzero reserved bits, a write with bit 0 set, and a slot-1 read with bit 0 set.
- R9: Window 5 always reads the revision word: board revision in bits 15:12, audio-present flag in bit 8, major revision in bits 7:4, minor revision in bits 3:0, and zeros elsewhere. Writes to it have no effect.
- R10: A read transfer changes only staging register 0. Staging registers 1 to 3 and the address register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Window write strobe |
| host_sel | input | 3 | Window select: 0 address, 1-4 staging 0-3, 5 revision, 6 status |
| host_wdata | input | 16 | Window write data |
| host_rdata | output | 16 | Contents of the selected window (combinational) |
| busy | output | 1 | Transfer in progress |

## Verification
Some internal faults are visible at the ports within one transfer. A wrong decode of the block, unit or slot makes a read return another register's word, or 0 where data was stored. A late or early commit shows up on the first read-back once busy falls. Other faults take longer to show. A corrupted word in the store stays hidden until that exact register is read, which is why random reads sweep the whole space many times. A miscounting sequencer is seen directly as a busy pulse of the wrong length. Staging registers that are not held while busy show up as a changed value on the next window read.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int WORD_W = 16;
  localparam int NBLK   = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    WIN_ADDR = 3'd0,
    WIN_D0   = 3'd1,
    WIN_D1   = 3'd2,
    WIN_D2   = 3'd3,
    WIN_D3   = 3'd4,
    WIN_REV  = 3'd5,
    WIN_STAT = 3'd6
  } win_sel_e;

  typedef struct packed {
    logic       hit;
    logic       rd;
    logic       wide;
    logic       word;
    logic [1:0] blk;
    logic [3:0] unit;
  } ireq_t;

  // maps a block-type code to its storage bank; bit 2 flags a known type
  function automatic logic [2:0] blk_lookup(input logic [3:0] code);
    case (code)
      4'h1:    return 3'b100;
      4'h2:    return 3'b101;
      4'h3:    return 3'b110;
      4'h9:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/ireg_decode.sv
module ireg_decode
  import ireg_pkg::*;
#(
  parameter int NUNIT = 4,
  parameter int EW    = 4
) (
  input  word_t          addr,
  output ireq_t          req,
  output logic [EW-1:0]  ent
);
  logic [2:0] bl;
  logic       unit_ok;
  logic       rsv_ok;
  logic       slot_ok;
  logic       idx_ok;
  logic [1:0] slot;
  int         ent_i;

  always_comb begin
    bl      = blk_lookup(addr[15:12]);
    slot    = addr[3:2];
    unit_ok = (addr[11:8] != 4'd0) && (int'(addr[11:8]) <= NUNIT);
    rsv_ok  = (addr[6:4] == 3'd0) && !addr[1];
    slot_ok = (slot == 2'd1) || (slot == 2'd2);
    // word index only meaningful on reads of the wide slot
    idx_ok  = !addr[0] || (addr[7] && slot == 2'd2);

    req.hit  = bl[2] && unit_ok && rsv_ok && slot_ok && idx_ok;
    req.rd   = addr[7];
    req.wide = (slot == 2'd2);
    req.word = addr[0];
    req.blk  = bl[1:0];
    req.unit = addr[11:8];

    ent_i = int'(bl[1:0]) * NUNIT + int'(addr[11:8]) - 1;
    if (!req.hit) ent_i = 0;
    ent = EW'(ent_i);
  end
endmodule

// File: rtl/ireg_store.sv
module ireg_store
  import ireg_pkg::*;
#(
  parameter int NENT = 16,
  parameter int EW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          we_wide,
  input  logic [EW-1:0] wr_ent,
  input  word_t         wd0,
  input  word_t         wd1,
  input  logic [EW-1:0] rd_ent,
  input  logic          rd_wide,
  input  logic          rd_word,
  output word_t         rdata
);
  logic [NENT*WORD_W-1:0]   narrow_flat;
  logic [NENT*2*WORD_W-1:0] wide_flat;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    word_t             narrow_q;
    logic [2*WORD_W-1:0] wide_q;
    logic              sel;

    assign sel = we && (wr_ent == EW'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        narrow_q <= '0;
        wide_q   <= '0;
      end else if (sel) begin
        if (we_wide) wide_q   <= {wd1, wd0};
        else         narrow_q <= wd0;
      end
    end

    assign narrow_flat[e*WORD_W +: WORD_W]     = narrow_q;
    assign wide_flat[e*2*WORD_W +: 2*WORD_W]   = wide_q;
  end

  always_comb begin
    if (!rd_wide)
      rdata = narrow_flat[int'(rd_ent)*WORD_W +: WORD_W];
    else if (rd_word)
      rdata = wide_flat[int'(rd_ent)*2*WORD_W + WORD_W +: WORD_W];
    else
      rdata = wide_flat[int'(rd_ent)*2*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq #(
  parameter int BUSY_CYCLES = 4,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int         NUNIT         = 4,
  parameter int         BUSY_CYCLES   = 4,
  parameter logic [3:0] REV_BOARD     = 4'd4,
  parameter logic [3:0] REV_MAJOR     = 4'd1,
  parameter logic [3:0] REV_MINOR     = 4'd0,
  parameter logic       AUDIO_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        busy
);
  localparam int NENT = NBLK * NUNIT;
  localparam int EW   = (NENT > 1) ? $clog2(NENT) : 1;
  localparam word_t REV_WORD = {REV_BOARD, 3'b000, AUDIO_PRESENT, REV_MAJOR, REV_MINOR};

  word_t          addr_q;
  word_t          dreg [4];
  logic           acc;
  logic           start;
  logic           done;
  ireq_t          req;
  logic [EW-1:0]  ent;
  word_t          st_rdata;

  assign acc   = host_we && !busy;
  assign start = acc && (host_sel == WIN_ADDR);

  ireg_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .done (done)
  );

  ireg_decode #(.NUNIT(NUNIT), .EW(EW)) u_dec (
    .addr(addr_q),
    .req (req),
    .ent (ent)
  );

  ireg_store #(.NENT(NENT), .EW(EW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (done && req.hit && !req.rd),
    .we_wide(req.wide),
    .wr_ent (ent),
    .wd0    (dreg[0]),
    .wd1    (dreg[1]),
    .rd_ent (ent),
    .rd_wide(req.wide),
    .rd_word(req.word),
    .rdata  (st_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (start) begin
      addr_q <= host_wdata;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dreg[i] <= '0;
      end else if (acc && host_sel == 3'(i + 1)) begin
        dreg[i] <= host_wdata;
      end else if (i == 0 && done && req.rd) begin
        dreg[i] <= req.hit ? st_rdata : '0;
      end
    end
  end

  always_comb begin
    case (host_sel)
      WIN_ADDR: host_rdata = addr_q;
      WIN_D0:   host_rdata = dreg[0];
      WIN_D1:   host_rdata = dreg[1];
      WIN_D2:   host_rdata = dreg[2];
      WIN_D3:   host_rdata = dreg[3];
      WIN_REV:  host_rdata = REV_WORD;
      WIN_STAT: host_rdata = {15'd0, busy};
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [2:0]  host_sel,
  input logic        busy,
  input logic [15:0] addr_q,
  input logic [15:0] d1,
  input logic [15:0] d2,
  input logic [15:0] d3
);
  localparam int RW = $clog2(BUSY_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 3'd0 && !busy) |=> busy);

  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_we && host_sel == 3'd0));

  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (int'(run) == BUSY_CYCLES));

  p_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run) < BUSY_CYCLES));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(d1) && $stable(d2) && $stable(d3)));
endmodule

bind ireg_bridge ireg_bridge_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .host_we (host_we),
  .host_sel(host_sel),
  .busy    (busy),
  .addr_q  (addr_q),
  .d1      (dreg[1]),
  .d2      (dreg[2]),
  .d3      (dreg[3])
);

// File: tb/test_ireg_bridge.sv
module test_ireg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_nar [4][5];
  logic [31:0] m_wid [4][5];

  always #10 clk = ~clk;

  ireg_bridge i_ireg_bridge (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  function automatic int bank(input logic [3:0] t);
    case (t)
      4'h1: return 0;
      4'h2: return 1;
      4'h3: return 2;
      4'h9: return 3;
      default: return -1;
    endcase
  endfunction

  // legality of an indirect address under the requirement layout
  function automatic bit legal(input logic [15:0] a);
    int u;
    u = int'(a[11:8]);
    if (bank(a[15:12]) < 0 || u < 1 || u > 4) return 0;
    if (a[6:4] != 0 || a[1]) return 0;
    if (a[3:2] != 2'd1 && a[3:2] != 2'd2) return 0;
    if (a[0] && !(a[7] && a[3:2] == 2'd2)) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    int b, u;
    if (!legal(a)) return 16'h0;
    b = bank(a[15:12]);
    u = int'(a[11:8]);
    if (a[3:2] == 2'd1) return m_nar[b][u];
    return a[0] ? m_wid[b][u][31:16] : m_wid[b][u][15:0];
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [15:0] w0, input logic [15:0] w1);
    int b, u;
    if (a[7] || !legal(a)) return;
    b = bank(a[15:12]);
    u = int'(a[11:8]);
    if (a[3:2] == 2'd1) m_nar[b][u] = w0;
    else                m_wid[b][u] = {w1, w0};
  endtask

  task automatic hwrite(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = s; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] s, output logic [15:0] v);
    host_sel = s;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_idle();
    int c = 0;
    while (busy && c < 50) begin
      c++;
      @(negedge clk);
    end
  endtask

  // address write plus timing check; returns at the first idle negedge
  task automatic access(input logic [15:0] a);
    int c = 0;
    logic [15:0] st;
    hwrite(3'd0, a);
    while (busy && c < 50) begin
      c++;
      @(negedge clk);
    end
    check("R2 busy length", 16'(c), 16'd4);
    hread(3'd6, st);
    check("R2 status idle", st, 16'h0);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] w0, input logic [15:0] w1);
    hwrite(3'd1, w0);
    hwrite(3'd2, w1);
    access(a);
    model_write(a, w0, w1);
  endtask

  task automatic do_read(input string req, input logic [15:0] a);
    logic [15:0] v, d1b, d1a;
    hread(3'd2, d1b);
    access(a);
    hread(3'd1, v);
    check(req, v, exp_read(a));
    hread(3'd2, d1a);
    check("R10 staging 1 kept", d1a, d1b);
  endtask

  initial begin
    logic [15:0] v;
    for (int b = 0; b < 4; b++)
      for (int u = 0; u < 5; u++) begin
        m_nar[b][u] = '0;
        m_wid[b][u] = '0;
      end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      hread(3'(s), v);
      check("R1 window reset", v, 16'h0);
    end
    hread(3'd6, v);
    check("R1 status reset", v, 16'h0);
    check("R1 busy reset", {15'd0, busy}, 16'h0);
    do_read("R1 store reset", 16'h1488);

    // R9 revision and its read-only behaviour
    hread(3'd5, v);
    check("R9 revision", v, 16'h4110);
    hwrite(3'd5, 16'hFFFF);
    hread(3'd5, v);
    check("R9 revision write ignored", v, 16'h4110);

    // R5 16-bit register
    do_write(16'h1404, 16'h0023, 16'h0000);
    do_read("R5 narrow readback", 16'h1484);
    // R6 32-bit register
    do_write(16'h1408, 16'h0123, 16'h0321);
    do_read("R6 wide word0", 16'h1488);
    do_read("R6 wide word1", 16'h1489);
    // R7 separate banks per type
    do_write(16'h9104, 16'hBEEF, 16'h0);
    do_write(16'h2308, 16'hA5A5, 16'h5A5A);
    do_read("R7 bank 9", 16'h9184);
    do_read("R7 bank 2 word1", 16'h2389);
    do_read("R7 bank 1 unchanged", 16'h1184);
    // R8 unimplemented accesses
    do_write(16'h5404, 16'h7777, 16'h7777);
    do_read("R8 unknown type reads 0", 16'h5484);
    do_write(16'h1409, 16'hDEAD, 16'hDEAD);
    do_read("R8 odd-index write ignored", 16'h1488);
    do_read("R8 narrow index1 reads 0", 16'h1485);
    do_write(16'h1004, 16'h1111, 16'h0);
    do_read("R8 unit 0 reads 0", 16'h1084);
    do_read("R4 unit 4 bank 1 intact", 16'h1484);

    // R3 writes while busy are dropped
    hwrite(3'd2, 16'h0AAA);
    hwrite(3'd0, 16'h1488);
    hwrite(3'd2, 16'h0BBB);
    hwrite(3'd0, 16'h9184);
    wait_idle();
    hread(3'd2, v);
    check("R3 staging held", v, 16'h0AAA);
    hread(3'd0, v);
    check("R3 address held", v, 16'h1488);
    hread(3'd1, v);
    check("R3 first transfer result", v, 16'h0123);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      int pick;
      pick = int'($urandom_range(0, 7));
      if (pick == 0) a = 16'($urandom);
      else begin
        logic [3:0] t;
        case ($urandom_range(0, 3))
          0: t = 4'h1;
          1: t = 4'h2;
          2: t = 4'h3;
          default: t = 4'h9;
        endcase
        a = {t, 4'($urandom_range(1, 4)), 1'b0, 3'b000,
             ($urandom_range(0, 1) != 0) ? 2'd2 : 2'd1, 1'b0, 1'b0};
      end
      if ($urandom_range(0, 1) != 0) begin
        a[7] = 1'b1;
        if (a[3:2] == 2'd2 && pick != 0) a[0] = 1'($urandom_range(0, 1));
        do_read("R4 random read", a);
      end else begin
        if (pick != 0) a[7] = 1'b0;
        do_write(a, 16'($urandom), 16'($urandom));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule